// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block manages a set of 8-bit general-purpose I/O ports. Each port holds an output data latch and a direction mask, and it watches its input pins for interrupt conditions. Every pin can be set to trigger on a level or on an edge, with either polarity. A register bus gives access to the configuration, to the pending status and to a write-one-to-clear acknowledge.

The default build has three ports. Ports 0 and 1 share one interrupt line, which goes high when any enabled pending bit in either port is set. Each pin of port 2 has its own interrupt line. Pin inputs pass through a two-flop synchroniser before any level check or edge detection.

The bus address is `{port[1:0], reg[2:0]}`. Register codes are: 0 data, 1 direction, 2 trigger mode, 3 trigger polarity, 4 enable, 5 status (read only) and 6 acknowledge (write only, reads 0). Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `gpirq_ctrl`

## Requirements
- R1: Trigger-mode register (code 2): a pin bit of 0 selects level detection and 1 selects edge detection.
- R2: Trigger-polarity register (code 3): a pin bit of 0 selects low level or falling edge, and 1 selects high level or rising edge.
- R3: A pin drives an interrupt line only while its enable bit (code 4) is 1. While the bit is 0, edges on that pin are not captured.
- R4: Writing the acknowledge register (code 6) clears the latched edge of every pin whose written bit is 1. Bits written as 0 leave their latches unchanged.
- R5: Status (code 5) shows one bit per pin. In level mode the bit is 1 while the synchronised pin equals its polarity bit. In edge mode the bit is a latch that holds until acknowledged.
- R6: `irq_shared` is the OR of (status AND enable) over all pins of ports 0 and 1.
- R7: `irq_pin[i]` is status AND enable of pin i of port 2.
- R8: For each port, `pin_oe` equals the direction register (1 = output) and `pin_out` equals the data latch. A data read returns the latch for output pins and the synchronised pin for input pins.
- R9: A pin change is visible in level status after two clock edges and in edge status after three.
- R10: After reset all writable registers and edge latches are 0, and every interrupt line is low.
- R11: Changing trigger mode or polarity never creates a pending edge. Switching a pin to level mode discards its latched edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Port index (bits 4:3) and register code (bits 2:0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 24 | Raw pin inputs, port p at bits 8p+7:8p |
| pin_out | output | 24 | Output data latches |
| pin_oe | output | 24 | Output enables (direction) |
| irq_shared | output | 1 | Combined interrupt of ports 0 and 1 |
| irq_pin | output | 8 | Per-pin interrupts of port 2 |

## Verification
The assertions assume that `rst_n` is low from time zero. They also assume that edge-mode status changes only through a captured pin transition, an acknowledge, or a change of trigger mode. The bench keeps to these assumptions: it changes pins only at falling clock edges and lets them settle for four cycles before the next operation, so every captured edge is fully synchronised. Register writes last one cycle and are followed by idle cycles. An acknowledge therefore never arrives in the same cycle as a fresh edge.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  // register codes inside one port window
  typedef enum logic [2:0] {
    RS_DATA  = 3'd0,
    RS_DIR   = 3'd1,
    RS_TMODE = 3'd2,
    RS_TPOL  = 3'd3,
    RS_EN    = 3'd4,
    RS_STAT  = 3'd5,
    RS_ACK   = 3'd6,
    RS_NONE  = 3'd7
  } reg_sel_e;

  localparam int unsigned REG_SEL_W = 3;
endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpirq_port.sv
module gpirq_port #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wdata,
  input  logic             wr_dout,
  input  logic             wr_dir,
  input  logic             wr_mode,
  input  logic             wr_pol,
  input  logic             wr_en,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dir,
  output logic [WIDTH-1:0] mode,
  output logic [WIDTH-1:0] pol,
  output logic [WIDTH-1:0] en
);
  logic [WIDTH-1:0] dout_q, dout_d;
  logic [WIDTH-1:0] dir_q,  dir_d;
  logic [WIDTH-1:0] mode_q, mode_d;
  logic [WIDTH-1:0] pol_q,  pol_d;
  logic [WIDTH-1:0] en_q,   en_d;

  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    mode_d = mode_q;
    pol_d  = pol_q;
    en_d   = en_q;
    if (wr_dout) dout_d = wdata;
    if (wr_dir)  dir_d  = wdata;
    if (wr_mode) mode_d = wdata;
    if (wr_pol)  pol_d  = wdata;
    if (wr_en)   en_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      mode_q <= mode_d;
      pol_q  <= pol_d;
      en_q   <= en_d;
    end
  end

  assign dout = dout_q;
  assign dir  = dir_q;
  assign mode = mode_q;
  assign pol  = pol_q;
  assign en   = en_q;
endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_s,
  input  logic [WIDTH-1:0] mode,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] en,
  input  logic [WIDTH-1:0] ack,
  output logic [WIDTH-1:0] stat
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] latch_q, latch_d;
  logic [WIDTH-1:0] rise, fall, hit, lvl;

  always_comb begin
    rise    = pin_s & ~prev_q;
    fall    = ~pin_s & prev_q;
    hit     = en & mode & ((pol & rise) | (~pol & fall));
    // a fresh edge wins over an acknowledge in the same cycle
    latch_d = mode & (hit | (latch_q & ~ack));
    lvl     = ~(pin_s ^ pol);
    stat    = (mode & latch_q) | (~mode & lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= pin_s;
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/gpirq_ctrl.sv
module gpirq_ctrl #(
  parameter int unsigned PORT_W       = 8,
  parameter int unsigned NUM_PORTS    = 3,
  parameter int unsigned SHARED_PORTS = 2,
  localparam int unsigned PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned ADDR_W   = PSEL_W + gpirq_pkg::REG_SEL_W,
  localparam int unsigned PIN_W    = PORT_W * NUM_PORTS,
  localparam int unsigned SH_W     = PORT_W * SHARED_PORTS,
  localparam int unsigned DED_PINS = PIN_W - SH_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [PORT_W-1:0]   bus_wdata,
  output logic [PORT_W-1:0]   bus_rdata,
  input  logic [PIN_W-1:0]    pin_in,
  output logic [PIN_W-1:0]    pin_out,
  output logic [PIN_W-1:0]    pin_oe,
  output logic                irq_shared,
  output logic [DED_PINS-1:0] irq_pin
);
  import gpirq_pkg::*;

  localparam int unsigned RS_W = REG_SEL_W;

  logic [PSEL_W-1:0] a_port;
  reg_sel_e          a_reg;

  assign a_port = bus_addr[ADDR_W-1:RS_W];
  assign a_reg  = reg_sel_e'(bus_addr[RS_W-1:0]);

  logic [PORT_W-1:0] dout_v [NUM_PORTS];
  logic [PORT_W-1:0] dir_v  [NUM_PORTS];
  logic [PORT_W-1:0] mode_v [NUM_PORTS];
  logic [PORT_W-1:0] pol_v  [NUM_PORTS];
  logic [PORT_W-1:0] en_v   [NUM_PORTS];
  logic [PORT_W-1:0] stat_v [NUM_PORTS];
  logic [PORT_W-1:0] sync_v [NUM_PORTS];

  logic [PIN_W-1:0] stat_all;
  logic [PIN_W-1:0] en_all;
  logic [PIN_W-1:0] mode_all;
  logic [PIN_W-1:0] ack_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              hit_port;
    logic [PORT_W-1:0] ack_mask;

    assign hit_port = bus_wr && (a_port == PSEL_W'(p));
    assign ack_mask = (hit_port && (a_reg == RS_ACK)) ? bus_wdata : '0;

    gpirq_port #(.WIDTH(PORT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdata   (bus_wdata),
      .wr_dout (hit_port && (a_reg == RS_DATA)),
      .wr_dir  (hit_port && (a_reg == RS_DIR)),
      .wr_mode (hit_port && (a_reg == RS_TMODE)),
      .wr_pol  (hit_port && (a_reg == RS_TPOL)),
      .wr_en   (hit_port && (a_reg == RS_EN)),
      .dout    (dout_v[p]),
      .dir     (dir_v[p]),
      .mode    (mode_v[p]),
      .pol     (pol_v[p]),
      .en      (en_v[p])
    );

    gpirq_sync #(.WIDTH(PORT_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in[p*PORT_W +: PORT_W]),
      .q     (sync_v[p])
    );

    gpirq_detect #(.WIDTH(PORT_W)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (sync_v[p]),
      .mode  (mode_v[p]),
      .pol   (pol_v[p]),
      .en    (en_v[p]),
      .ack   (ack_mask),
      .stat  (stat_v[p])
    );

    assign pin_out [p*PORT_W +: PORT_W] = dout_v[p];
    assign pin_oe  [p*PORT_W +: PORT_W] = dir_v[p];
    assign stat_all[p*PORT_W +: PORT_W] = stat_v[p];
    assign en_all  [p*PORT_W +: PORT_W] = en_v[p];
    assign mode_all[p*PORT_W +: PORT_W] = mode_v[p];
    assign ack_all [p*PORT_W +: PORT_W] = ack_mask;
  end

  // register read mux
  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (a_port == PSEL_W'(p)) begin
        case (a_reg)
          RS_DATA:  bus_rdata = (dir_v[p] & dout_v[p]) | (~dir_v[p] & sync_v[p]);
          RS_DIR:   bus_rdata = dir_v[p];
          RS_TMODE: bus_rdata = mode_v[p];
          RS_TPOL:  bus_rdata = pol_v[p];
          RS_EN:    bus_rdata = en_v[p];
          RS_STAT:  bus_rdata = stat_v[p];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_shared = |(stat_all[SH_W-1:0] & en_all[SH_W-1:0]);
  assign irq_pin    = stat_all[PIN_W-1:SH_W] & en_all[PIN_W-1:SH_W];
endmodule

// File: rtl/gpirq_ctrl_chk.sv
module gpirq_ctrl_chk #(
  parameter int unsigned PIN_W    = 24,
  parameter int unsigned SH_W     = 16,
  parameter int unsigned DED_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [PIN_W-1:0]    stat_all,
  input logic [PIN_W-1:0]    en_all,
  input logic [PIN_W-1:0]    mode_all,
  input logic [PIN_W-1:0]    ack_all,
  input logic [PIN_W-1:0]    pin_oe,
  input logic                irq_shared,
  input logic [DED_PINS-1:0] irq_pin
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq_shared && (irq_pin == '0))); // R10

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_all & mode_all & ~ack_all) & mode_all & ~stat_all) == '0)); // R5

  AST_NO_SPURIOUS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mode_all & $past(mode_all) & ~$past(en_all) & stat_all & ~$past(stat_all)) == '0)); // R11

  AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin & ~en_all[PIN_W-1:SH_W]) == '0); // R7

  AST_SHARED_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all[SH_W-1:0] == '0) |-> !irq_shared); // R6

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_oe)); // R8
endmodule

bind gpirq_ctrl gpirq_ctrl_chk #(
  .PIN_W    (PIN_W),
  .SH_W     (SH_W),
  .DED_PINS (DED_PINS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .stat_all   (stat_all),
  .en_all     (en_all),
  .mode_all   (mode_all),
  .ack_all    (ack_all),
  .pin_oe     (pin_oe),
  .irq_shared (irq_shared),
  .irq_pin    (irq_pin)
);

// File: tb/gpirq_ctrl_test.sv
module gpirq_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in;
  logic [23:0] pin_out;
  logic [23:0] pin_oe;
  logic        irq_shared;
  logic [7:0]  irq_pin;

  gpirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_shared(irq_shared), .irq_pin(irq_pin)
  );

  int n_chk = 0;
  int n_bad = 0;

  bit [7:0] m_dout[3], m_dir[3], m_mode[3], m_pol[3], m_en[3], m_latch[3];

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic bit [7:0] pins_of(int p);
    return pin_in[p*8 +: 8];
  endfunction

  function automatic bit [7:0] exp_stat(int p);
    return (m_mode[p] & m_latch[p]) | (~m_mode[p] & ~(pins_of(p) ^ m_pol[p]));
  endfunction

  function automatic bit [7:0] exp_data(int p);
    return (m_dir[p] & m_dout[p]) | (~m_dir[p] & pins_of(p));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(int p, int sel, output logic [7:0] v);
    bus_addr = {p[1:0], sel[2:0]};
    #1;
    v = bus_rdata;
  endtask

  task automatic do_wr(int p, int sel, bit [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {p[1:0], sel[2:0]}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (sel)
      0: m_dout[p] = d;
      1: m_dir[p]  = d;
      2: begin m_mode[p] = d; m_latch[p] &= d; end
      3: m_pol[p]  = d;
      4: m_en[p]   = d;
      6: m_latch[p] &= ~d;
      default: ;
    endcase
    repeat (2) @(negedge clk);
  endtask

  task automatic do_pins(bit [23:0] np);
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      bit [7:0] o, n, r, f;
      o = pin_in[p*8 +: 8]; n = np[p*8 +: 8];
      r = n & ~o; f = ~n & o;
      m_latch[p] |= m_en[p] & m_mode[p] & ((m_pol[p] & r) | (~m_pol[p] & f));
    end
    pin_in = np;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string ctx);
    logic [7:0] v;
    bit [7:0] sh;
    sh = 8'h00;
    for (int p = 0; p < 3; p++) begin
      rd(p, 5, v); chk({ctx, " R5 status"}, v, exp_stat(p));
      rd(p, 0, v); chk({ctx, " R8 data"}, v, exp_data(p));
      rd(p, 1, v); chk({ctx, " R8 dir"}, v, m_dir[p]);
      rd(p, 2, v); chk({ctx, " R1 mode"}, v, m_mode[p]);
      rd(p, 3, v); chk({ctx, " R2 pol"}, v, m_pol[p]);
      rd(p, 4, v); chk({ctx, " R3 en"}, v, m_en[p]);
      if (p < 2) sh |= exp_stat(p) & m_en[p];
    end
    chk({ctx, " R6 irq_shared"}, irq_shared, |sh);
    chk({ctx, " R7 irq_pin"}, irq_pin, exp_stat(2) & m_en[2]);
    chk({ctx, " R8 pin_oe"}, pin_oe, {m_dir[2], m_dir[1], m_dir[0]});
    chk({ctx, " R8 pin_out"}, pin_out, {m_dout[2], m_dout[1], m_dout[0]});
  endtask

  // watchdog
  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < 3; p++) begin
      m_dout[p] = 0; m_dir[p] = 0; m_mode[p] = 0; m_pol[p] = 0; m_en[p] = 0; m_latch[p] = 0;
    end
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 irq_shared at reset", irq_shared, 1'b0);
    chk("R10 irq_pin at reset", irq_pin, 8'h00);
    rd(0, 4, v); chk("R10 enable at reset", v, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R10 after reset");

    // R9: level latency (port 0 pin 0, level high)
    do_wr(0, 3, 8'h01);
    do_wr(0, 4, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk); rd(0, 5, v); chk("R9 level after 1 edge", v[0], 1'b0);
    @(negedge clk); rd(0, 5, v); chk("R9 level after 2 edges", v[0], 1'b1);
    chk("R9 R6 irq_shared level", irq_shared, 1'b1);
    @(negedge clk); pin_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 level drop");

    // R9: edge latency (port 0 pin 1, rising edge)
    do_wr(0, 2, 8'h02);
    do_wr(0, 3, 8'h02);
    do_wr(0, 4, 8'h02);
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk); @(negedge clk); rd(0, 5, v); chk("R9 edge after 2 edges", v[1], 1'b0);
    @(negedge clk); rd(0, 5, v); chk("R9 edge after 3 edges", v[1], 1'b1);
    m_latch[0][1] = 1'b1;
    repeat (2) @(negedge clk);
    do_pins(pin_in & ~24'h2);
    check_all("R5 sticky after pin falls");
    do_wr(0, 6, 8'hFD);
    rd(0, 5, v); chk("R4 ack zero bit keeps latch", v[1], 1'b1);
    do_wr(0, 6, 8'h02);
    rd(0, 5, v); chk("R4 ack one bit clears latch", v[1], 1'b0);

    // R2: falling edge on port 1 pin 4
    do_wr(1, 2, 8'h10); do_wr(1, 4, 8'h10);
    do_pins(pin_in | 24'h1000);
    rd(1, 5, v); chk("R2 rising ignored when falling selected", v[4], 1'b0);
    do_pins(pin_in & ~24'h1000);
    rd(1, 5, v); chk("R2 falling captured", v[4], 1'b1);
    check_all("R6 shared from port 1");

    // R11 / R3: disabled edge pin, polarity toggle and pin edge
    do_wr(2, 2, 8'h08); do_wr(2, 3, 8'h08);
    do_pins(pin_in | 24'h08_0000);
    do_wr(2, 3, 8'h00);
    do_wr(2, 3, 8'h08);
    rd(2, 5, v); chk("R11 R3 no pending while disabled", v[3], 1'b0);
    do_wr(2, 4, 8'h08);
    do_pins(pin_in & ~24'h08_0000);
    do_wr(2, 3, 8'h00);
    do_pins(pin_in | 24'h08_0000);
    do_pins(pin_in & ~24'h08_0000);
    chk("R7 irq_pin3 on falling edge", irq_pin[3], 1'b1);
    do_wr(2, 4, 8'h00);
    chk("R3 masked irq_pin3", irq_pin[3], 1'b0);
    rd(2, 5, v); chk("R3 status kept while masked", v[3], 1'b1);
    do_wr(2, 2, 8'h00);
    do_wr(2, 2, 8'h08);
    rd(2, 5, v); chk("R11 level switch discards latch", v[3], 1'b0);

    // R8: outputs and data readback
    do_wr(1, 1, 8'hF0); do_wr(1, 0, 8'hA5);
    check_all("R8 direction mix");

    // constrained random
    for (int it = 0; it < 600; it++) begin
      int p, op;
      p  = $urandom_range(0, 2);
      op = $urandom_range(0, 7);
      case (op)
        0: do_wr(p, 0, 8'($urandom));
        1: do_wr(p, 1, 8'($urandom));
        2: do_wr(p, 2, 8'($urandom));
        3: do_wr(p, 3, 8'($urandom));
        4: do_wr(p, 4, 8'($urandom));
        5: do_wr(p, 6, 8'($urandom));
        default: do_pins(pin_in ^ (24'($urandom) & 24'($urandom)));
      endcase
      check_all("rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule